// File: doc/BRIEF.md
# Vector-Loop Instruction Issue Sequencer

This block is the control sequencer that sits between an instruction-fetch port and an execute-unit port in a core with a short vector prefix. It asks for an instruction at the current program counter, holds the fetched words steady for the decoder, and then decides on its own whether the instruction runs at all. A prefixed instruction whose vector length is zero is skipped straight back to fetch. Otherwise the execute unit is started once per element, with a one-cycle re-decode pulse between elements, and no refetch happens inside the loop.

The sequencer owns two architectural registers: the program counter and a vector state word that holds the current element step and the vector length. When an element finishes, three outcomes are possible. The execute unit may have redirected either register itself, and then its values are kept untouched. The loop may be complete, and then the counter advances by 4 for a plain instruction or 8 for a prefixed one. Otherwise the step advances and the next element runs. An external stop request is sampled only while the sequencer waits to start an instruction. While it is stopped, software-side write ports may load both registers.

Top module: `vloop_issue_seq`

## Requirements
- R1: After reset the sequencer waits at instruction start with `pc_o` = RESET_PC (default 0) and `vstate_o` = 0, and it raises no fetch request while `stop_req` is high.
- R2: `stop_req` is looked at only at instruction start; an instruction or element loop already under way runs to completion, and the sequencer then stays idle with no fetch request.
- R3: `ext_pc_we`/`ext_vs_we` load the registers only while the sequencer is stopped at instruction start, and the loaded PC is the address of the next fetch; at any other time these writes have no effect.
- R4: A prefixed instruction with VL = 0 gets no execute start, produces one `insn_done` pulse, and the PC advances by 8.
- R5: A plain (unprefixed) instruction is executed once and the PC advances by 4.
- R6: A prefixed instruction with a vector output runs execute once per element from the current step up to VL-1, pulses `elem_redecode` for one cycle before every repeat, and on the last element advances the PC by 8 and clears the step to 0. `vstate_o` holds the step in bits [6:0] and VL in bits [13:7].
- R7: A prefixed instruction without a vector output is executed once, the PC advances by 8, and the step is left unchanged.
- R8: When execute writes the PC or the vector state (during the execute-wait phase), the loop ends at that element, the written value is kept, and the sequencer applies no PC advance, step increment or step clear of its own.
- R9: `pc_chg_o`/`vs_chg_o` are set by execute writes, stay stable after the instruction ends, and are cleared only when the next fetch request is accepted.
- R10: `dec_word`, `dec_prefix` and `dec_prefixed` hold the fetched values unchanged from the fetch response until the next fetch response, across all elements of a loop.
- R11: `insn_done` is a one-cycle pulse for each execute completion and for each zero-length skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Hold the core at the next instruction start |
| ext_pc_we | input | 1 | Load the PC while stopped |
| ext_pc_wdata | input | 32 | Value for the external PC load |
| ext_vs_we | input | 1 | Load the vector state while stopped |
| ext_vs_wdata | input | 14 | Value for the external vector state load |
| fetch_req_valid | output | 1 | Fetch request |
| fetch_req_ready | input | 1 | Fetch unit accepts the request |
| fetch_req_addr | output | 32 | Fetch address (current PC) |
| fetch_rsp_valid | input | 1 | Fetched instruction is present |
| fetch_rsp_word | input | 32 | Fetched instruction word |
| fetch_rsp_prefixed | input | 1 | Instruction carries a vector prefix |
| fetch_rsp_prefix | input | 32 | Prefix word |
| dec_word | output | 32 | Held instruction word for the decoder |
| dec_prefix | output | 32 | Held prefix word for the decoder |
| dec_prefixed | output | 1 | Held prefix flag for the decoder |
| dec_vec_out | input | 1 | Decoder: instruction has a vector output |
| elem_redecode | output | 1 | One-cycle pulse: re-derive register numbers for the new step |
| exec_valid | output | 1 | Execute start request |
| exec_ready | input | 1 | Execute unit accepts the start |
| exec_done | input | 1 | Execute unit finished the element |
| exec_pc_we | input | 1 | Execute redirects the PC |
| exec_pc_wdata | input | 32 | Redirected PC value |
| exec_vs_we | input | 1 | Execute rewrites the vector state |
| exec_vs_wdata | input | 14 | Rewritten vector state value |
| pc_o | output | 32 | Program counter |
| vstate_o | output | 14 | Vector state: step [6:0], VL [13:7] |
| pc_chg_o | output | 1 | PC was written by execute in this instruction |
| vs_chg_o | output | 1 | Vector state was written by execute in this instruction |
| insn_done | output | 1 | Instruction/element completion pulse |

## Verification
The bench pushes on the loop exits. Vectors start at a nonzero step, so a design that counts from zero runs too many elements. A redirect in the middle of a loop catches a design that still increments or clears the step, or adds 4 or 8 on top of the redirected PC. The zero-length skip catches a design that starts execute or advances by 4. A stop raised during a loop catches a design that abandons the remaining elements. External writes driven while the core runs catch a design that accepts them outside the stopped state. The change flags are read both after the instruction ends and after the next one begins, so a design that clears them early, or never clears them, is reported.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_FETCH_WAIT = 3'd1,
    S_DECODE     = 3'd2,
    S_DECODE_SV  = 3'd3,
    S_EXEC_START = 3'd4,
    S_EXEC_WAIT  = 3'd5
  } seq_state_e;

  // register-file commands issued by the control FSM
  typedef struct packed {
    logic pc_adv;    // advance PC by instruction length
    logic adv8;      // length is 8 (prefixed) instead of 4
    logic step_clr;  // clear element step
    logic step_inc;  // next element
    logic chg_clr;   // new instruction starts: clear change flags
    logic ext_ok;    // stopped at start: external writes allowed
    logic exec_ok;   // execute in flight: redirect writes allowed
  } reg_cmd_t;

endpackage

// File: rtl/vls_rst_sync.sv
module vls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vls_insn_hold.sv
module vls_insn_hold #(
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              in_loop,
  input  logic [INSN_W-1:0] word_i,
  input  logic [INSN_W-1:0] prefix_i,
  input  logic              prefixed_i,
  output logic [INSN_W-1:0] word_o,
  output logic [INSN_W-1:0] prefix_o,
  output logic              prefixed_o
);
  logic [INSN_W-1:0] word_q, prefix_q;
  logic              prefixed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      prefix_q   <= '0;
      prefixed_q <= 1'b0;
    end else if (capture) begin
      word_q     <= word_i;
      prefix_q   <= prefix_i;
      prefixed_q <= prefixed_i;
    end
  end

  assign word_o     = word_q;
  assign prefix_o   = prefix_q;
  assign prefixed_o = prefixed_q;

  AST_OPCODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_loop && $past(in_loop)) |-> ($stable(word_q) && $stable(prefix_q) && $stable(prefixed_q))); // R10

endmodule

// File: rtl/vls_arch_regs.sv
module vls_arch_regs
  import vls_pkg::*;
#(
  parameter int             PC_W     = 32,
  parameter int             STEP_W   = 7,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  reg_cmd_t            cmd,
  input  logic                ext_pc_we,
  input  logic [PC_W-1:0]     ext_pc_wdata,
  input  logic                ext_vs_we,
  input  logic [2*STEP_W-1:0] ext_vs_wdata,
  input  logic                exec_pc_we,
  input  logic [PC_W-1:0]     exec_pc_wdata,
  input  logic                exec_vs_we,
  input  logic [2*STEP_W-1:0] exec_vs_wdata,
  output logic [PC_W-1:0]     pc_o,
  output logic [STEP_W-1:0]   step_o,
  output logic [STEP_W-1:0]   vl_o,
  output logic                pc_chg_o,
  output logic                vs_chg_o
);
  localparam logic [PC_W-1:0]   LEN4 = PC_W'(4);
  localparam logic [PC_W-1:0]   LEN8 = PC_W'(8);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  logic [PC_W-1:0]   pc_q, pc_d;
  logic              pc_en;
  logic [STEP_W-1:0] step_q, step_d, vl_q, vl_d;
  logic              vs_en;
  logic              pc_chg_q, pc_chg_d, vs_chg_q, vs_chg_d, chg_en;
  logic              ext_pc_hit, ext_vs_hit, exe_pc_hit, exe_vs_hit;

  assign ext_pc_hit = cmd.ext_ok  && ext_pc_we;
  assign ext_vs_hit = cmd.ext_ok  && ext_vs_we;
  assign exe_pc_hit = cmd.exec_ok && exec_pc_we;
  assign exe_vs_hit = cmd.exec_ok && exec_vs_we;

  // PC next value
  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (ext_pc_hit) begin
      pc_d  = ext_pc_wdata;
      pc_en = 1'b1;
    end else if (exe_pc_hit) begin
      pc_d  = exec_pc_wdata;
      pc_en = 1'b1;
    end else if (cmd.pc_adv) begin
      pc_d  = pc_q + (cmd.adv8 ? LEN8 : LEN4);
      pc_en = 1'b1;
    end
  end

  // vector state next value
  always_comb begin
    step_d = step_q;
    vl_d   = vl_q;
    vs_en  = 1'b0;
    if (ext_vs_hit) begin
      step_d = ext_vs_wdata[STEP_W-1:0];
      vl_d   = ext_vs_wdata[2*STEP_W-1:STEP_W];
      vs_en  = 1'b1;
    end else if (exe_vs_hit) begin
      step_d = exec_vs_wdata[STEP_W-1:0];
      vl_d   = exec_vs_wdata[2*STEP_W-1:STEP_W];
      vs_en  = 1'b1;
    end else if (cmd.step_clr) begin
      step_d = '0;
      vs_en  = 1'b1;
    end else if (cmd.step_inc) begin
      step_d = step_q + ONE;
      vs_en  = 1'b1;
    end
  end

  // change flags
  always_comb begin
    pc_chg_d = pc_chg_q;
    vs_chg_d = vs_chg_q;
    chg_en   = 1'b0;
    if (cmd.chg_clr) begin
      pc_chg_d = 1'b0;
      vs_chg_d = 1'b0;
      chg_en   = 1'b1;
    end else if (exe_pc_hit || exe_vs_hit) begin
      pc_chg_d = pc_chg_q | exe_pc_hit;
      vs_chg_d = vs_chg_q | exe_vs_hit;
      chg_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      vl_q   <= '0;
    end else if (vs_en) begin
      step_q <= step_d;
      vl_q   <= vl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_chg_q <= 1'b0;
      vs_chg_q <= 1'b0;
    end else if (chg_en) begin
      pc_chg_q <= pc_chg_d;
      vs_chg_q <= vs_chg_d;
    end
  end

  assign pc_o     = pc_q;
  assign step_o   = step_q;
  assign vl_o     = vl_q;
  assign pc_chg_o = pc_chg_q;
  assign vs_chg_o = vs_chg_q;

  AST_PC_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q != $past(pc_q)) |-> ($past(cmd.pc_adv) || $past(ext_pc_hit) || $past(exe_pc_hit))); // R3

  AST_CHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_chg_q && !cmd.chg_clr) |=> pc_chg_q); // R9

  AST_REDIRECT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_pc_hit && !exe_vs_hit) |=> $stable(step_q)); // R8

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              fetch_req_ready,
  input  logic              fetch_rsp_valid,
  input  logic              exec_ready,
  input  logic              exec_done,
  input  logic              exec_pc_we,
  input  logic              exec_vs_we,
  input  logic              prefixed,
  input  logic              dec_vec_out,
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] vl,
  input  logic              pc_chg,
  input  logic              vs_chg,
  output reg_cmd_t          cmd,
  output logic              fetch_req_valid,
  output logic              capture,
  output logic              in_loop,
  output logic              exec_valid,
  output logic              elem_redecode,
  output logic              insn_done
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  seq_state_e state_q, state_d;
  logic       last_elem, zero_vl, redirected;

  assign last_elem  = (step == (vl - ONE));
  assign zero_vl    = (vl == '0);
  assign redirected = pc_chg || vs_chg || exec_pc_we || exec_vs_we;

  always_comb begin
    state_d         = state_q;
    cmd             = '0;
    fetch_req_valid = 1'b0;
    capture         = 1'b0;
    exec_valid      = 1'b0;
    elem_redecode   = 1'b0;
    insn_done       = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        cmd.ext_ok      = stop_req;
        fetch_req_valid = !stop_req;
        if (!stop_req && fetch_req_ready) begin
          cmd.chg_clr = 1'b1;
          state_d     = S_FETCH_WAIT;
        end
      end
      S_FETCH_WAIT: begin
        if (fetch_rsp_valid) begin
          capture = 1'b1;
          state_d = S_DECODE;
        end
      end
      S_DECODE: begin
        if (prefixed && zero_vl) begin
          insn_done  = 1'b1;
          cmd.pc_adv = 1'b1;
          cmd.adv8   = 1'b1;
          state_d    = S_IDLE;
        end else begin
          state_d = S_EXEC_START;
        end
      end
      S_DECODE_SV: begin
        elem_redecode = 1'b1;
        state_d       = S_EXEC_START;
      end
      S_EXEC_START: begin
        exec_valid = 1'b1;
        if (exec_ready) state_d = S_EXEC_WAIT;
      end
      S_EXEC_WAIT: begin
        cmd.exec_ok = 1'b1;
        if (exec_done) begin
          insn_done = 1'b1;
          if (redirected) begin
            state_d = S_IDLE;
          end else if (!prefixed || !dec_vec_out || last_elem) begin
            cmd.pc_adv   = 1'b1;
            cmd.adv8     = prefixed;
            cmd.step_clr = prefixed && dec_vec_out && last_elem;
            state_d      = S_IDLE;
          end else begin
            cmd.step_inc = 1'b1;
            state_d      = S_DECODE_SV;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign in_loop = (state_q == S_DECODE) || (state_q == S_DECODE_SV) ||
                   (state_q == S_EXEC_START) || (state_q == S_EXEC_WAIT);

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && stop_req) |=> (state_q == S_IDLE)); // R1

  AST_DECSV_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DECODE_SV) |=> (state_q == S_EXEC_START)); // R6

  AST_SKIP_NEEDS_ZERO_VL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_DECODE && state_q == S_IDLE) |-> ($past(vl) == '0 && $past(prefixed))); // R4

endmodule

// File: rtl/vloop_issue_seq.sv
module vloop_issue_seq
  import vls_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              STEP_W   = 7,
  parameter int              INSN_W   = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                ext_pc_we,
  input  logic [PC_W-1:0]     ext_pc_wdata,
  input  logic                ext_vs_we,
  input  logic [2*STEP_W-1:0] ext_vs_wdata,
  output logic                fetch_req_valid,
  input  logic                fetch_req_ready,
  output logic [PC_W-1:0]     fetch_req_addr,
  input  logic                fetch_rsp_valid,
  input  logic [INSN_W-1:0]   fetch_rsp_word,
  input  logic                fetch_rsp_prefixed,
  input  logic [INSN_W-1:0]   fetch_rsp_prefix,
  output logic [INSN_W-1:0]   dec_word,
  output logic [INSN_W-1:0]   dec_prefix,
  output logic                dec_prefixed,
  input  logic                dec_vec_out,
  output logic                elem_redecode,
  output logic                exec_valid,
  input  logic                exec_ready,
  input  logic                exec_done,
  input  logic                exec_pc_we,
  input  logic [PC_W-1:0]     exec_pc_wdata,
  input  logic                exec_vs_we,
  input  logic [2*STEP_W-1:0] exec_vs_wdata,
  output logic [PC_W-1:0]     pc_o,
  output logic [2*STEP_W-1:0] vstate_o,
  output logic                pc_chg_o,
  output logic                vs_chg_o,
  output logic                insn_done
);
  logic              rst_sync_n;
  reg_cmd_t          cmd;
  logic              capture, in_loop;
  logic [STEP_W-1:0] step, vl;

  vls_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vls_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .stop_req        (stop_req),
    .fetch_req_ready (fetch_req_ready),
    .fetch_rsp_valid (fetch_rsp_valid),
    .exec_ready      (exec_ready),
    .exec_done       (exec_done),
    .exec_pc_we      (exec_pc_we),
    .exec_vs_we      (exec_vs_we),
    .prefixed        (dec_prefixed),
    .dec_vec_out     (dec_vec_out),
    .step            (step),
    .vl              (vl),
    .pc_chg          (pc_chg_o),
    .vs_chg          (vs_chg_o),
    .cmd             (cmd),
    .fetch_req_valid (fetch_req_valid),
    .capture         (capture),
    .in_loop         (in_loop),
    .exec_valid      (exec_valid),
    .elem_redecode   (elem_redecode),
    .insn_done       (insn_done)
  );

  vls_insn_hold #(.INSN_W(INSN_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .capture    (capture),
    .in_loop    (in_loop),
    .word_i     (fetch_rsp_word),
    .prefix_i   (fetch_rsp_prefix),
    .prefixed_i (fetch_rsp_prefixed),
    .word_o     (dec_word),
    .prefix_o   (dec_prefix),
    .prefixed_o (dec_prefixed)
  );

  vls_arch_regs #(.PC_W(PC_W), .STEP_W(STEP_W), .RESET_PC(RESET_PC)) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cmd           (cmd),
    .ext_pc_we     (ext_pc_we),
    .ext_pc_wdata  (ext_pc_wdata),
    .ext_vs_we     (ext_vs_we),
    .ext_vs_wdata  (ext_vs_wdata),
    .exec_pc_we    (exec_pc_we),
    .exec_pc_wdata (exec_pc_wdata),
    .exec_vs_we    (exec_vs_we),
    .exec_vs_wdata (exec_vs_wdata),
    .pc_o          (pc_o),
    .step_o        (step),
    .vl_o          (vl),
    .pc_chg_o      (pc_chg_o),
    .vs_chg_o      (vs_chg_o)
  );

  assign fetch_req_addr = pc_o;
  assign vstate_o       = {vl, step};

  AST_INSN_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    insn_done |=> !insn_done); // R11

endmodule

// File: tb/sim_vloop_issue_seq.sv
module sim_vloop_issue_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stop_req;
  logic        ext_pc_we;
  logic [31:0] ext_pc_wdata;
  logic        ext_vs_we;
  logic [13:0] ext_vs_wdata;
  logic        fetch_req_valid, fetch_req_ready;
  logic [31:0] fetch_req_addr;
  logic        fetch_rsp_valid, fetch_rsp_prefixed;
  logic [31:0] fetch_rsp_word, fetch_rsp_prefix;
  logic [31:0] dec_word, dec_prefix;
  logic        dec_prefixed, dec_vec_out, elem_redecode;
  logic        exec_valid, exec_ready, exec_done;
  logic        exec_pc_we, exec_vs_we;
  logic [31:0] exec_pc_wdata;
  logic [13:0] exec_vs_wdata;
  logic [31:0] pc_o;
  logic [13:0] vstate_o;
  logic        pc_chg_o, vs_chg_o, insn_done;

  int total = 0;
  int bad   = 0;

  int          r_exec, r_done, r_redec, r_opc_bad;
  logic [31:0] r_addr;
  logic        r_quiet;

  always #5 clk = ~clk;

  vloop_issue_seq u0 (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
    .ext_pc_we(ext_pc_we), .ext_pc_wdata(ext_pc_wdata),
    .ext_vs_we(ext_vs_we), .ext_vs_wdata(ext_vs_wdata),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_word(fetch_rsp_word), .fetch_rsp_prefixed(fetch_rsp_prefixed),
    .fetch_rsp_prefix(fetch_rsp_prefix), .dec_word(dec_word),
    .dec_prefix(dec_prefix), .dec_prefixed(dec_prefixed),
    .dec_vec_out(dec_vec_out), .elem_redecode(elem_redecode),
    .exec_valid(exec_valid), .exec_ready(exec_ready), .exec_done(exec_done),
    .exec_pc_we(exec_pc_we), .exec_pc_wdata(exec_pc_wdata),
    .exec_vs_we(exec_vs_we), .exec_vs_wdata(exec_vs_wdata),
    .pc_o(pc_o), .vstate_o(vstate_o), .pc_chg_o(pc_chg_o),
    .vs_chg_o(vs_chg_o), .insn_done(insn_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one instruction through fetch/decode/execute, acting as fetch and execute units
  task automatic serve(input logic pfx, input logic vout, input logic [31:0] word,
                       input int redir_elem, input logic redir_vs,
                       input logic [31:0] rpc, input logic [13:0] rvs,
                       input logic raise_stop, input logic poke);
    logic f_pend = 1'b0;
    logic e_pend = 1'b0;
    logic started = 1'b0;
    int   quiet = 0;
    int   elem = 0;
    r_exec = 0; r_done = 0; r_redec = 0; r_opc_bad = 0; r_quiet = 1'b0; r_addr = '0;
    dec_vec_out = vout;
    if (poke) begin
      ext_pc_we = 1'b1; ext_pc_wdata = 32'hDEAD_BEEC;
      ext_vs_we = 1'b1; ext_vs_wdata = 14'h3FFF;
    end
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      fetch_req_ready = 1'b0; exec_ready = 1'b0;
      exec_pc_we = 1'b0; exec_vs_we = 1'b0;
      fetch_rsp_valid = f_pend; fetch_rsp_word = word;
      fetch_rsp_prefixed = pfx; fetch_rsp_prefix = word ^ 32'h5A5A_0F0F;
      exec_done = e_pend;
      if (e_pend && elem == redir_elem) begin
        if (redir_vs) begin exec_vs_we = 1'b1; exec_vs_wdata = rvs; end
        else          begin exec_pc_we = 1'b1; exec_pc_wdata = rpc; end
      end
      f_pend = 1'b0; e_pend = 1'b0;
      #1;
      if (insn_done) r_done++;
      if (exec_done) elem++;
      if (elem_redecode) r_redec++;
      if (fetch_req_valid) begin
        if (started) break;
        started = 1'b1;
        r_addr = fetch_req_addr;
        fetch_req_ready = 1'b1;
        f_pend = 1'b1;
      end
      if (exec_valid) begin
        r_exec++;
        if (dec_word !== word || dec_prefixed !== pfx) r_opc_bad++;
        exec_ready = 1'b1;
        e_pend = 1'b1;
        if (raise_stop) stop_req = 1'b1;
      end
      if (!exec_valid && !fetch_req_valid && !f_pend && !e_pend && !insn_done && !exec_done)
        quiet++;
      else
        quiet = 0;
      if (started && quiet >= 8) begin r_quiet = 1'b1; break; end
    end
    ext_pc_we = 1'b0; ext_vs_we = 1'b0;
  endtask

  task automatic ext_write(input logic [31:0] pc, input logic [13:0] vs);
    @(negedge clk);
    ext_pc_we = 1'b1; ext_pc_wdata = pc;
    ext_vs_we = 1'b1; ext_vs_wdata = vs;
    @(negedge clk);
    ext_pc_we = 1'b0; ext_vs_we = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    int seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (fetch_req_valid || insn_done) seen++;
    end
    chk("R1 no fetch while stopped", seen, 0);
    chk("R1 reset pc", pc_o, 32'h0);
    chk("R1 reset vstate", {18'h0, vstate_o}, 32'h0);
  endtask

  task automatic t_stopped_write;
    ext_write(32'h100, {7'd3, 7'd0});
    chk("R3 stopped pc load", pc_o, 32'h100);
    chk("R3 stopped vstate load", {18'h0, vstate_o}, 32'h180);
    stop_req = 1'b0;
  endtask

  task automatic t_plain;
    serve(1'b0, 1'b0, 32'h1111_0001, -1, 1'b0, '0, '0, 1'b0, 1'b0);
    chk("R3 first fetch at loaded pc", r_addr, 32'h100);
    chk("R5 plain exec count", r_exec, 1);
    chk("R5 plain pc+4", pc_o, 32'h104);
    chk("R11 plain done pulses", r_done, 1);
    chk("R7 plain keeps vstate", {18'h0, vstate_o}, 32'h180);
  endtask

  task automatic t_vector_loop;
    serve(1'b1, 1'b1, 32'h2222_0002, -1, 1'b0, '0, '0, 1'b0, 1'b1);
    chk("R6 element count", r_exec, 3);
    chk("R6 redecode pulses", r_redec, 2);
    chk("R11 done per element", r_done, 3);
    chk("R6 pc+8 and R3 poke ignored", pc_o, 32'h10C);
    chk("R6 step cleared", {18'h0, vstate_o}, 32'h180);
    chk("R10 opcode held", r_opc_bad, 0);
  endtask

  task automatic t_no_vec_out;
    serve(1'b1, 1'b0, 32'h3333_0003, -1, 1'b0, '0, '0, 1'b0, 1'b0);
    chk("R7 single exec", r_exec, 1);
    chk("R7 pc+8", pc_o, 32'h114);
    chk("R7 vstate unchanged", {18'h0, vstate_o}, 32'h180);
  endtask

  task automatic t_pc_redirect;
    serve(1'b1, 1'b1, 32'h4444_0004, 1, 1'b0, 32'h400, '0, 1'b0, 1'b0);
    chk("R8 exec stops at redirect", r_exec, 2);
    chk("R8 pc from execute", pc_o, 32'h400);
    chk("R8 step not cleared", {18'h0, vstate_o}, 32'h181);
    chk("R9 pc flag set", pc_chg_o, 1);
    chk("R9 vs flag clear", vs_chg_o, 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 pc flag held after end", pc_chg_o, 1);
  endtask

  task automatic t_from_step1;
    serve(1'b1, 1'b1, 32'h5555_0005, -1, 1'b0, '0, '0, 1'b0, 1'b0);
    chk("R9 flag cleared by next insn", pc_chg_o, 0);
    chk("R6 runs from current step", r_exec, 2);
    chk("R6 pc+8 after partial loop", pc_o, 32'h408);
    chk("R6 step cleared after partial loop", {18'h0, vstate_o}, 32'h180);
  endtask

  task automatic t_vs_redirect;
    serve(1'b1, 1'b1, 32'h6666_0006, 0, 1'b1, '0, 14'h000, 1'b0, 1'b0);
    chk("R8 vs redirect ends loop", r_exec, 1);
    chk("R8 no own pc advance", pc_o, 32'h408);
    chk("R8 vstate from execute", {18'h0, vstate_o}, 32'h0);
    chk("R9 vs flag set", vs_chg_o, 1);
  endtask

  task automatic t_zero_vl;
    serve(1'b1, 1'b1, 32'h7777_0007, -1, 1'b0, '0, '0, 1'b0, 1'b0);
    chk("R4 no execute", r_exec, 0);
    chk("R4 one done pulse", r_done, 1);
    chk("R4 pc+8", pc_o, 32'h410);
  endtask

  task automatic t_stop;
    serve(1'b0, 1'b0, 32'h8888_0008, -1, 1'b0, '0, '0, 1'b1, 1'b0);
    chk("R2 stopped after insn", r_quiet, 1);
    chk("R2 insn completed", pc_o, 32'h414);
    chk("R2 no fetch while stopped", fetch_req_valid, 0);
    ext_write(32'h414, {7'd2, 7'd0});
    chk("R3 vstate load in stop", {18'h0, vstate_o}, 32'h100);
    stop_req = 1'b0;
    serve(1'b1, 1'b1, 32'h9999_0009, -1, 1'b0, '0, '0, 1'b1, 1'b0);
    chk("R2 loop finishes despite stop", r_exec, 2);
    chk("R2 pc after loop", pc_o, 32'h41C);
    chk("R2 stopped after loop", r_quiet, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stop_req = 1'b1;
    ext_pc_we = 1'b0; ext_pc_wdata = '0; ext_vs_we = 1'b0; ext_vs_wdata = '0;
    fetch_req_ready = 1'b0; fetch_rsp_valid = 1'b0; fetch_rsp_word = '0;
    fetch_rsp_prefixed = 1'b0; fetch_rsp_prefix = '0; dec_vec_out = 1'b0;
    exec_ready = 1'b0; exec_done = 1'b0; exec_pc_we = 1'b0; exec_pc_wdata = '0;
    exec_vs_we = 1'b0; exec_vs_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_stopped_write();
    t_plain();
    t_vector_loop();
    t_no_vec_out();
    t_pc_redirect();
    t_from_step1();
    t_vs_redirect();
    t_zero_vl();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule